// File: doc/BRIEF.md
# UART Sleep-Mode Power Controller

This block decides when a UART core may stop its baud-clock oscillator and when that oscillator must run again. It watches the serial receive line, the four active-low modem status inputs, the transmit-FIFO write strobe, the transmit empty flag, the receive-FIFO occupancy and the interrupt-pending flag. It also holds a sleep-enable bit of its own. A configuration write can change that bit only while the enhanced-features enable input is high.

While sleep is enabled, the controller drops the oscillator enable once the transmitter is empty, the receive FIFO holds nothing and no interrupt is pending. Any of the following wakes it: a start bit on the receive line, a level change on any modem input, a host write into the transmit FIFO, a pending interrupt, or clearing of the enable bit. The oscillator restart is modelled by a counter of `RESTART_CYC` clock cycles. After that count, a one-cycle ready strobe tells the core that its clock is usable again. While the enable bit stays set, the controller returns to sleep by itself once activity ends.

The controller has three states. In AWAKE the oscillator runs and activity is tracked. In SLEEP the oscillator is gated. In RESTART the oscillator runs and the restart delay is counted. The transitions are:
- AWAKE→SLEEP ("settle"): enabled, idle, no interrupt and no wake event.
- SLEEP→RESTART ("rouse"): a wake event or the enable bit cleared.
- RESTART→AWAKE ("ready"): the counter expires, which fires the strobe.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset the oscillator enable is 1, the sleep indicator and the ready strobe are 0, and sleep is disabled.
- R2: A configuration write changes the sleep-enable bit only when `feat_en_i` is 1. A write with `feat_en_i` at 0 leaves the block awake even when the written bit is 1 and the block is idle.
- R3: When sleep is enabled and the block is idle, the block enters sleep. Idle means transmit empty, receive count 0, no interrupt and no wake event. Entry happens at the second clock edge after the enabling write. While asleep, `osc_en_o` is 0 and `asleep_o` is 1.
- R4: The block never shows sleep while `irq_pend_i` is 1. A pending interrupt raises `osc_en_o` in the same cycle, even in SLEEP. It also starts a restart, and the ready strobe follows at edge RESTART_CYC+1.
- R5: A falling edge on `rx_i` wakes the block. The edge passes a two-flop synchroniser, and the ready strobe appears at the (RESTART_CYC+3)th clock edge after the line falls. A rising edge does not wake the block.
- R6: A level change in either direction on any one of `ri_n_i`, `cts_n_i`, `dsr_n_i` or `cd_n_i` wakes the block. The comparison is against a copy taken while awake, and the strobe appears at edge RESTART_CYC+3.
- R7: A one-cycle pulse on `txf_wr_i` in SLEEP wakes the block, and the strobe appears at edge RESTART_CYC+1.
- R8: `wake_rdy_o` is a single-cycle pulse. It appears only as RESTART is left, exactly RESTART_CYC cycles after RESTART is entered. The oscillator runs throughout RESTART.
- R9: After a wake, with sleep still enabled, the block re-enters sleep one edge after it becomes idle again.
- R10: A write that clears the sleep-enable bit raises `osc_en_o` after the next clock edge. The block then completes a restart (strobe at edge RESTART_CYC+2 after the write) and stays awake.
- R11: The block does not enter sleep while `tx_empty_i` is 0 or `rxf_count_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running reference clock |
| rst_n | input | 1 | active-low asynchronous reset |
| rx_i | input | 1 | serial receive line, idle high |
| ri_n_i | input | 1 | ring indicator, active low |
| cts_n_i | input | 1 | clear to send, active low |
| dsr_n_i | input | 1 | data set ready, active low |
| cd_n_i | input | 1 | carrier detect, active low |
| txf_wr_i | input | 1 | host write strobe into the transmit FIFO |
| tx_empty_i | input | 1 | transmit FIFO and shift register both empty |
| rxf_count_i | input | RXQ_W | receive FIFO occupancy |
| irq_pend_i | input | 1 | any interrupt pending |
| feat_en_i | input | 1 | enhanced-features enable, gates config writes |
| cfg_wr_i | input | 1 | configuration write strobe |
| cfg_sleep_i | input | 1 | sleep-enable value carried by the write |
| osc_en_o | output | 1 | oscillator enable |
| asleep_o | output | 1 | sleep state indicator |
| wake_rdy_o | output | 1 | one-cycle strobe after the restart delay |

## Verification
Each wake source is applied alone to a sleeping block: a receive-line fall, a fall on each modem line in turn, a rise on one modem line, a transmit write, a pending interrupt and a disabling write. The measured cycle of the ready strobe separates the synchronised paths (RESTART_CYC+3) from the direct paths (RESTART_CYC+1) and from the register-delayed disable path (RESTART_CYC+2). Busy patterns, namely a non-empty transmitter, a nonzero receive count and a held interrupt, show that sleep is withheld until activity ends and then re-entered. A gated write with the feature enable low shows that the enable bit cannot be set that way.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
    typedef enum logic [1:0] {
        PS_AWAKE   = 2'd0,
        PS_SLEEP   = 2'd1,
        PS_RESTART = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/uart_sleep_sync.sv
module uart_sleep_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [0:0] RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RST_VAL}};
            sync_q <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/uart_sleep_wake.sv
module uart_sleep_wake #(
    parameter int MODEM_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_i,
    input  logic [MODEM_N-1:0] modem_i,
    input  logic               track_i,
    output logic               start_o,
    output logic               change_o
);
    logic               rx_s;
    logic               rx_prev_q;
    logic [MODEM_N-1:0] mdm_s;
    logic [MODEM_N-1:0] snap_q;
    logic [MODEM_N-1:0] diff;

    uart_sleep_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uart_sleep_sync #(.WIDTH(MODEM_N), .RST_VAL(1'b1)) u_mdm_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (modem_i),
        .q_o   (mdm_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_s;
        end
    end

    assign start_o = rx_prev_q & ~rx_s;

    generate
        for (genvar i = 0; i < MODEM_N; i++) begin : g_line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    snap_q[i] <= 1'b1;
                end else if (track_i) begin
                    snap_q[i] <= mdm_s[i];
                end
            end
            assign diff[i] = mdm_s[i] ^ snap_q[i];
        end
    endgenerate

    assign change_o = |diff;
endmodule

// File: rtl/uart_sleep_timer.sv
module uart_sleep_timer #(
    parameter int LIMIT = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
#(
    parameter int RESTART_CYC = 6000,
    parameter int RXQ_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             ri_n_i,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             cd_n_i,
    input  logic             txf_wr_i,
    input  logic             tx_empty_i,
    input  logic [RXQ_W-1:0] rxf_count_i,
    input  logic             irq_pend_i,
    input  logic             feat_en_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_sleep_i,
    output logic             osc_en_o,
    output logic             asleep_o,
    output logic             wake_rdy_o
);
    localparam int MODEM_N = 4;

    pwr_state_e st_q, st_d;
    logic       sleep_en_q;
    logic       rdy_q;
    logic       wake_start, wake_change;
    logic       restart_done;
    logic       idle;
    logic       wake_evt;
    logic       gated;

    uart_sleep_wake #(.MODEM_N(MODEM_N)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_i     (rx_i),
        .modem_i  ({cd_n_i, dsr_n_i, cts_n_i, ri_n_i}),
        .track_i  (st_q != PS_SLEEP),
        .start_o  (wake_start),
        .change_o (wake_change)
    );

    uart_sleep_timer #(.LIMIT(RESTART_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q == PS_RESTART),
        .done_o (restart_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_en_q <= 1'b0;
        end else if (cfg_wr_i && feat_en_i) begin
            sleep_en_q <= cfg_sleep_i;
        end
    end

    assign idle     = tx_empty_i && (rxf_count_i == '0) && !txf_wr_i;
    assign wake_evt = wake_start || wake_change || txf_wr_i || irq_pend_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_AWAKE:   if (sleep_en_q && idle && !wake_evt) st_d = PS_SLEEP;
            PS_SLEEP:   if (wake_evt || !sleep_en_q)         st_d = PS_RESTART;
            PS_RESTART: if (restart_done)                    st_d = PS_AWAKE;
            default:                                         st_d = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_AWAKE;
            rdy_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            rdy_q <= (st_q == PS_RESTART) && restart_done;
        end
    end

    always_comb begin
        gated      = (st_q == PS_SLEEP) && sleep_en_q && !irq_pend_i;
        osc_en_o   = !gated;
        asleep_o   = gated;
        wake_rdy_o = rdy_q;
    end

    assert_no_sleep_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_AWAKE && irq_pend_i) |=> st_q != PS_SLEEP);
    assert_gated_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !feat_en_i) |=> $stable(sleep_en_q));
    assert_enter_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_AWAKE && sleep_en_q && idle && !wake_evt) |=> asleep_o || irq_pend_i);
    assert_rx_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SLEEP && wake_start) |=> st_q == PS_RESTART);
    assert_modem_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SLEEP && wake_change) |=> st_q == PS_RESTART);
    assert_txwr_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SLEEP && txf_wr_i) |=> st_q == PS_RESTART);
    assert_rdy_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rdy_o |-> $past(st_q) == PS_RESTART && st_q == PS_AWAKE);
    assert_rdy_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rdy_o |=> !wake_rdy_o);
    assert_clear_wakes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && feat_en_i && !cfg_sleep_i) |=> osc_en_o);
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_AWAKE && (!tx_empty_i || rxf_count_i != '0)) |=> st_q != PS_SLEEP);
endmodule

// File: tb/uart_sleep_ctrl_tb.sv
`timescale 1ns/100ps
module uart_sleep_ctrl_tb;
    localparam int RC    = 24;
    localparam int RXQ_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic [3:0]       mdm_n = 4'hF;
    logic             txf_wr = 1'b0;
    logic             tx_empty = 1'b1;
    logic [RXQ_W-1:0] rxcnt = '0;
    logic             irq = 1'b0;
    logic             feat_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_sleep = 1'b0;
    logic             osc_en, asleep, wake_rdy;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int inv_bad = 0;
    int exp_q[$];
    string tag_q[$];
    logic rdy_prev = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_sleep_ctrl #(.RESTART_CYC(RC), .RXQ_W(RXQ_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx),
        .ri_n_i      (mdm_n[0]),
        .cts_n_i     (mdm_n[1]),
        .dsr_n_i     (mdm_n[2]),
        .cd_n_i      (mdm_n[3]),
        .txf_wr_i    (txf_wr),
        .tx_empty_i  (tx_empty),
        .rxf_count_i (rxcnt),
        .irq_pend_i  (irq),
        .feat_en_i   (feat_en),
        .cfg_wr_i    (cfg_wr),
        .cfg_sleep_i (cfg_sleep),
        .osc_en_o    (osc_en),
        .asleep_o    (asleep),
        .wake_rdy_o  (wake_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic expect_rdy(input int lat, input string req);
        exp_q.push_back(cyc + lat);
        tag_q.push_back(req);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic cfg_write(input logic f, input logic s);
        cfg_wr = 1'b1; feat_en = f; cfg_sleep = s;
        @(negedge clk);
        cfg_wr = 1'b0; feat_en = 1'b0;
    endtask

    // monitor: scoreboard for ready strobes plus the sleep/interrupt invariant
    always @(negedge clk) begin
        if (rst_n) begin
            if (asleep && irq) inv_bad++;
            if (wake_rdy) begin
                if (rdy_prev) chk(1'b0, "R8 strobe longer than one cycle", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected ready strobe", cyc, -1);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(cyc == e, t, cyc, e);
                end
            end
            rdy_prev = wake_rdy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(osc_en == 1'b1, "R1 osc_en", osc_en, 1);
        chk(asleep == 1'b0, "R1 asleep", asleep, 0);
        chk(wake_rdy == 1'b0, "R1 wake_rdy", wake_rdy, 0);

        // R2: write ignored without feature enable
        cfg_write(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk(asleep == 1'b0 && osc_en == 1'b1, "R2 gated write ignored", asleep, 0);

        // R3: proper enable puts the idle block to sleep
        cfg_write(1'b1, 1'b1);
        @(negedge clk);
        chk(asleep == 1'b1, "R3 asleep", asleep, 1);
        chk(osc_en == 1'b0, "R3 osc gated", osc_en, 0);

        // R5: receive start bit
        rx = 1'b0;
        expect_rdy(RC + 3, "R5 rx wake latency");
        repeat (RC + 6) @(negedge clk);
        rx = 1'b1;
        drained("R5 rx wake produced strobe");
        repeat (4) @(negedge clk);
        chk(asleep == 1'b1, "R9 re-sleep after rx wake, R5 rise ignored", asleep, 1);

        // R7: transmit write, then R11/R9 on the transmit-busy flag
        txf_wr = 1'b1; tx_empty = 1'b0;
        expect_rdy(RC + 1, "R7 tx write wake latency");
        @(negedge clk);
        txf_wr = 1'b0;
        repeat (RC + 4) @(negedge clk);
        drained("R7 tx write produced strobe");
        chk(asleep == 1'b0 && osc_en == 1'b1, "R11 awake while tx busy", asleep, 0);
        tx_empty = 1'b1;
        @(negedge clk);
        chk(asleep == 1'b1, "R9 re-sleep when tx empties", asleep, 1);

        // R6: each modem line alone, falling
        for (int i = 0; i < 4; i++) begin
            mdm_n[i] = 1'b0;
            if (i == 0) rxcnt = 5'd3;
            expect_rdy(RC + 3, "R6 modem fall wake latency");
            repeat (RC + 6) @(negedge clk);
            drained("R6 modem fall produced strobe");
            if (i == 0) begin
                chk(asleep == 1'b0, "R11 awake while rx count nonzero", asleep, 0);
                rxcnt = '0;
                @(negedge clk);
                chk(asleep == 1'b1, "R9 re-sleep when rx drained", asleep, 1);
            end else begin
                chk(asleep == 1'b1, "R9 re-sleep after modem wake", asleep, 1);
            end
        end
        // R6: rising change
        mdm_n[2] = 1'b1;
        expect_rdy(RC + 3, "R6 modem rise wake latency");
        repeat (RC + 6) @(negedge clk);
        drained("R6 modem rise produced strobe");

        // R4: interrupt while asleep
        chk(asleep == 1'b1, "R4 precondition asleep", asleep, 1);
        irq = 1'b1;
        expect_rdy(RC + 1, "R4 irq wake latency");
        #1;
        chk(osc_en == 1'b1 && asleep == 1'b0, "R4 osc on same cycle as irq", osc_en, 1);
        repeat (RC + 4) @(negedge clk);
        drained("R4 irq produced strobe");
        repeat (5) @(negedge clk);
        chk(asleep == 1'b0 && osc_en == 1'b1, "R4 stays awake while irq pending", asleep, 0);
        irq = 1'b0;
        @(negedge clk);
        chk(asleep == 1'b1, "R9 re-sleep after irq clears", asleep, 1);

        // R10: clearing the enable
        expect_rdy(RC + 2, "R10 disable restart latency");
        cfg_write(1'b1, 1'b0);
        chk(osc_en == 1'b1, "R10 osc on after one edge", osc_en, 1);
        repeat (RC + 4) @(negedge clk);
        drained("R10 disable produced strobe");
        repeat (5) @(negedge clk);
        chk(asleep == 1'b0 && osc_en == 1'b1, "R10 stays awake when disabled", asleep, 0);

        chk(inv_bad == 0, "R4 never asleep with irq pending", inv_bad, 0);
        summary();
        $finish;
    end
endmodule